// File: doc/BRIEF.md
# Keyed Commit Guard for Alternate-Function Select

This unit protects one 8-bit configuration register, the alternate-function select of a GPIO port, from stray writes. Software first writes a 32-bit magic key to a lock register. While the unit is unlocked, software may rewrite an 8-bit commit mask. Each set bit of that mask allows the matching bit of the alternate-function register to be written. Cleared mask bits keep their stored value no matter what data arrives.

The unit sits on the same simple register bus as the GPIO port: a write strobe, a byte-lane strobe, a 12-bit offset, 32-bit write data and a combinational read-data return. It exports the lock state, the commit mask and the protected value so that the port can use them directly.

Top module: `keyguard_top`

## Requirements
- R1: After reset the unit is locked, the commit mask is 0xFF and the alternate-function register is 0x00.
- R2: A write to offset 0x520 with all four byte strobes set and data exactly 0x0ACCE551 unlocks the unit from the next clock cycle.
- R3: Any other write to offset 0x520 locks the unit from the next cycle, including while it is unlocked. This covers a different value and any strobe pattern other than 4'b1111.
- R4: The lock state changes only on writes to offset 0x520.
- R5: A write to offset 0x524 while unlocked stores write data bits [7:0] as the commit mask. While locked, such a write has no effect.
- R6: A write to offset 0x420 changes only the alternate-function bits whose commit-mask bit is 1. The other bits keep their value.
- R7: Writes to offsets 0x524 and 0x420 take effect only when byte strobe bit 0 is set.
- R8: Reads are combinational. Offset 0x520 returns 1 when locked and 0 when unlocked. Offset 0x524 returns the commit mask and offset 0x420 returns the alternate-function value, each zero-extended. Every other offset returns 0.
- R9: Writes to offsets other than 0x420, 0x520 and 0x524 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_strb | input | 4 | Byte-lane enables of the write |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| locked_o | output | 1 | 1 while the unit is locked |
| commit_mask_o | output | 8 | Current commit mask |
| altfn_o | output | 8 | Protected alternate-function select |

## Verification
The assertions assume a write lasts exactly one cycle per request and that the offset and strobes are known whenever bus_wr is high. The stability properties would otherwise mix consecutive writes. The bench drives every write as a single-cycle pulse on the falling edge and returns bus_wr to 0 on the next falling edge. It also leaves the offset at a defined value at all times. For R6 it sweeps all 256 commit masks, writing two complementary data patterns under each mask.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;
   localparam int unsigned KG_ADDR_W   = 12;
   localparam int unsigned KG_DATA_W   = 32;
   localparam int unsigned KG_REG_W    = 8;
   localparam logic [31:0] KG_KEY      = 32'h0ACC_E551;
   localparam logic [11:0] KG_OFF_ALTF = 12'h420;
   localparam logic [11:0] KG_OFF_LOCK = 12'h520;
   localparam logic [11:0] KG_OFF_CMIT = 12'h524;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ALTF = 2'd1,
      SEL_LOCK = 2'd2,
      SEL_CMIT = 2'd3
   } kg_sel_e;
endpackage

// File: rtl/kg_lock.sv
module kg_lock #(
   parameter int unsigned          DATA_W = 32,
   parameter logic [DATA_W-1:0]    KEY    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W/8-1:0] strb,
   output logic              locked
);
   localparam int unsigned STRB_W = DATA_W / 8;

   logic full_lanes;
   logic key_ok;

   assign full_lanes = &strb;
   assign key_ok     = full_lanes && (wdata == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  locked <= 1'b1;
      else if (wr) locked <= ~key_ok;
   end

   AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (strb == {STRB_W{1'b1}}) && (wdata == KEY)) |=> !locked); // R2
   AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ((strb != {STRB_W{1'b1}}) || (wdata != KEY))) |=> locked); // R3
   AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(locked)); // R4
endmodule

// File: rtl/kg_commit.sv
module kg_commit #(
   parameter int unsigned       REG_W    = 8,
   parameter logic [REG_W-1:0]  RST_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             locked,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] mask
);
   logic accept;
   assign accept = wr & ~locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask <= RST_MASK;
      else if (accept) mask <= wdata;
   end

   AST_LOCKED_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(mask)); // R5
   AST_UNLOCKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !locked) |=> (mask == $past(wdata))); // R5
endmodule

// File: rtl/kg_masked_reg.sv
module kg_masked_reg #(
   parameter int unsigned       REG_W   = 8,
   parameter logic [REG_W-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] wmask,
   output logic [REG_W-1:0] q
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      logic bit_we;
      assign bit_we = wr & wmask[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= RST_VAL[i];
         else if (bit_we) q[i] <= wdata[i];
      end

      AST_MASKED_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !wmask[i] |=> $stable(q[i])); // R6
   end
endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
   import keyguard_pkg::*;
#(
   parameter int unsigned          ADDR_W   = KG_ADDR_W,
   parameter int unsigned          DATA_W   = KG_DATA_W,
   parameter int unsigned          REG_W    = KG_REG_W,
   parameter logic [DATA_W-1:0]    KEY      = KG_KEY,
   parameter logic [ADDR_W-1:0]    OFF_ALTF = KG_OFF_ALTF,
   parameter logic [ADDR_W-1:0]    OFF_LOCK = KG_OFF_LOCK,
   parameter logic [ADDR_W-1:0]    OFF_CMIT = KG_OFF_CMIT
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_wr,
   input  logic [DATA_W/8-1:0]   bus_strb,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic                  locked_o,
   output logic [REG_W-1:0]      commit_mask_o,
   output logic [REG_W-1:0]      altfn_o
);
   localparam int unsigned PAD_W = DATA_W - REG_W;

   if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
      $error("keyguard_top: DATA_W must be a positive multiple of 8");
   end
   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg
      $error("keyguard_top: REG_W must lie in 1..8 to fit byte lane 0");
   end
   if (OFF_ALTF == OFF_LOCK || OFF_ALTF == OFF_CMIT || OFF_LOCK == OFF_CMIT) begin : g_bad_map
      $error("keyguard_top: register offsets must be distinct");
   end

   kg_sel_e wsel;
   kg_sel_e rsel;

   always_comb begin
      if (bus_addr == OFF_LOCK)      rsel = SEL_LOCK;
      else if (bus_addr == OFF_CMIT) rsel = SEL_CMIT;
      else if (bus_addr == OFF_ALTF) rsel = SEL_ALTF;
      else                           rsel = SEL_NONE;
      wsel = bus_wr ? rsel : SEL_NONE;
   end

   logic lane0;
   assign lane0 = bus_strb[0];

   logic wr_lock, wr_cmit, wr_altf;
   assign wr_lock = (wsel == SEL_LOCK);
   assign wr_cmit = (wsel == SEL_CMIT) && lane0;
   assign wr_altf = (wsel == SEL_ALTF) && lane0;

   kg_lock #(.DATA_W(DATA_W), .KEY(KEY)) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_lock),
      .wdata  (bus_wdata),
      .strb   (bus_strb),
      .locked (locked_o)
   );

   kg_commit #(.REG_W(REG_W), .RST_MASK({REG_W{1'b1}})) u_commit (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_cmit),
      .locked (locked_o),
      .wdata  (bus_wdata[REG_W-1:0]),
      .mask   (commit_mask_o)
   );

   kg_masked_reg #(.REG_W(REG_W), .RST_VAL({REG_W{1'b0}})) u_altf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_altf),
      .wdata  (bus_wdata[REG_W-1:0]),
      .wmask  (commit_mask_o),
      .q      (altfn_o)
   );

   always_comb begin
      unique case (rsel)
         SEL_LOCK: bus_rdata = {{(DATA_W-1){1'b0}}, locked_o};
         SEL_CMIT: bus_rdata = {{PAD_W{1'b0}}, commit_mask_o};
         SEL_ALTF: bus_rdata = {{PAD_W{1'b0}}, altfn_o};
         default:  bus_rdata = '0;
      endcase
   end

   AST_NO_LANE0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_strb[0]) |=> ($stable(commit_mask_o) && $stable(altfn_o))); // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(commit_mask_o) && $stable(altfn_o) && $stable(locked_o))); // R9
   AST_LOCK_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == OFF_LOCK) |-> (bus_rdata == {{(DATA_W-1){1'b0}}, locked_o})); // R8
endmodule

// File: tb/keyguard_top_test.sv
`timescale 1ns/1ps
module keyguard_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_strb = 4'h0;
   logic [11:0] bus_addr = 12'h000;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        locked_o;
   logic [7:0]  commit_mask_o;
   logic [7:0]  altfn_o;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic       e_lock;
   logic [7:0] e_mask;
   logic [7:0] e_af;

   always #10 clk = ~clk;

   keyguard_top uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_strb(bus_strb),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .locked_o(locked_o), .commit_mask_o(commit_mask_o), .altfn_o(altfn_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s;
      @(negedge clk);
      bus_wr = 1'b0; bus_strb = 4'h0;
      if (a == 12'h520) e_lock = !((s == 4'hF) && (d == 32'h0ACCE551));
      else if (a == 12'h524 && s[0] && !e_lock) e_mask = d[7:0];
      else if (a == 12'h420 && s[0]) e_af = (e_af & ~e_mask) | (d[7:0] & e_mask);
   endtask

   task automatic check_all(input string req);
      check(req, {31'b0, locked_o}, {31'b0, e_lock});
      check(req, {24'b0, commit_mask_o}, {24'b0, e_mask});
      check(req, {24'b0, altfn_o}, {24'b0, e_af});
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(req, bus_rdata, exp);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            summary();
         end
      end
   end

   initial begin
      e_lock = 1'b1; e_mask = 8'hFF; e_af = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset");
      rd("R8 lock read", 12'h520, 32'h1);
      rd("R8 commit read", 12'h524, 32'hFF);
      rd("R8 altfn read", 12'h420, 32'h0);

      // R5: commit write while locked is ignored
      wr(12'h524, 32'h0F, 4'hF);
      check_all("R5 locked commit");
      // R3: partial-strobe key and wrong value keep it locked
      wr(12'h520, 32'h0ACCE551, 4'h7);
      check_all("R3 partial key");
      wr(12'h520, 32'h0ACCE550, 4'hF);
      check_all("R3 wrong key");
      // R2: exact key unlocks
      wr(12'h520, 32'h0ACCE551, 4'hF);
      check_all("R2 unlock");
      rd("R8 unlocked read", 12'h520, 32'h0);
      // R9 / R4: other offsets change nothing
      wr(12'h528, 32'hFFFF_FFFF, 4'hF);
      check_all("R9 other offset");
      wr(12'h000, 32'h0ACCE551, 4'hF);
      check_all("R4 lock stable");
      rd("R8 unmapped read", 12'h528, 32'h0);
      // R7: lane 0 strobe off ignores commit/altfn writes
      wr(12'h524, 32'h00, 4'hE);
      check_all("R7 commit no lane0");
      wr(12'h420, 32'hA5, 4'hE);
      check_all("R7 altfn no lane0");
      // R6: sweep every commit mask with two complementary patterns
      for (int m = 0; m < 256; m++) begin
         logic [7:0] p;
         p = 8'(m * 37 + 5);
         wr(12'h524, {24'hABCDEF, 8'(m)}, 4'h1);
         wr(12'h420, {24'h0, p}, 4'h1);
         check_all("R6 masked write a");
         wr(12'h420, {24'h0, ~p}, 4'hF);
         check_all("R6 masked write b");
         rd("R8 altfn sweep", 12'h420, {24'h0, e_af});
      end
      // R5: commit write while unlocked, then R3 relock while unlocked
      wr(12'h524, 32'h3C, 4'hF);
      check_all("R5 unlocked commit");
      wr(12'h520, 32'h1, 4'hF);
      check_all("R3 relock");
      wr(12'h524, 32'hC3, 4'hF);
      check_all("R5 commit after relock");
      wr(12'h420, 32'hFF, 4'hF);
      check_all("R6 altfn after relock");
      rd("R8 commit final", 12'h524, {24'h0, e_mask});
      summary();
   end
endmodule